// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel. A counter clock enable paces it, a gate input either pauses it or restarts it depending on the mode, and a load strobe arms it with a new reload value. It drives one registered output whose waveform depends on the selected mode, and it presents the count value that a reader would see. There are six modes: terminal-count flag, one-shot, rate pulse, square wave, and two single-pulse strobes. One of the strobes is retriggered by the gate and the other is paced by it.

A mode-select write parks the channel. Counting stops and the output takes the idle level of the new mode until the next load. A load restarts counting from the new value. Only the enabled clock cycles that follow the load advance it. Counting is binary only. Byte sequencing, bus decode and interrupt delivery belong to the surrounding logic.

In the requirements, N is the loaded value, with a load of 0 taken as 65536. d is the number of counted cycles since the last load or restart. A counted cycle is a clock edge with `cnt_en` high. In modes 0 and 4 that edge also needs `gate_i` high.

Top module: `ivt_channel`

## Requirements
- R1: A load value of 0 acts as N = 65536. The cycle after any load, `count_o` equals the loaded 16-bit value.
- R2: Mode selector values 6 and 7 behave exactly as modes 2 and 3.
- R3: A rising edge on `gate_i` resets d to 0 in modes 1, 2, 3 and 5. In modes 0 and 4, `gate_i` low stops d from advancing, and gate edges do not restart.
- R4: Mode 0: `out_o` is 1 exactly when d >= N. Once high, it stays high until the next load or mode write.
- R5: Mode 1: `out_o` is 1 while d < N and 0 from d = N on.
- R6: Mode 2: `out_o` is 1 exactly when d mod N = 0 and d != 0, which is a one-cycle pulse every N counted cycles.
- R7: Mode 3: `out_o` is 1 when (d mod N) < ceil(N/2). `count_o` = N - ((2d) mod N), so it steps down by two.
- R8: Modes 4 and 5: `out_o` is 1 only while d = N.
- R9: `count_o` = (N - d) mod 65536 in modes 0, 1, 4 and 5, and N - (d mod N) in mode 2, taken mod 65536.
- R10: A load takes priority over a counted cycle in the same edge. Cycles with `cnt_en` low change neither `count_o` nor `out_o`.
- R11: A mode write (`mode_wr_i`, selector `mode_i`) stops counting. On the next cycle `out_o` is 1 for modes 1, 2 and 3 and 0 otherwise. After reset the channel is in idle mode 0 with `out_o` = 0 and `count_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter clock enable |
| gate_i | input | 1 | Gate level |
| load_i | input | 1 | Load strobe for `load_val_i` |
| load_val_i | input | 16 | Reload value, 0 meaning 65536 |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode selector |
| out_o | output | 1 | Registered channel output |
| count_o | output | 16 | Current count as seen by a reader |

## Verification
Several properties are checked on every cycle. Idle cycles leave the output and count frozen. A load always shows the loaded value one cycle later. A mode write lands on the mode's idle level. The mode 0 flag and the spent mode 1 level never change on their own. The exact waveforms are left to the bench. These are the pulse positions in mode 2, the square-wave duty for odd and even N, the strobe position in modes 4 and 5, gate retrigger versus pause, and the 65536 case. The bench compares every cycle against the elapsed-count formulas.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    M_TERM   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_AT_TC = 2'd2,
    ST_PAST  = 2'd3
  } stage_e;

  // selectors 6 and 7 fold onto the periodic modes
  function automatic mode_e map_mode(input logic [2:0] sel);
    logic [2:0] v;
    if (sel == 3'd6)      v = 3'd2;
    else if (sel == 3'd7) v = 3'd3;
    else                  v = sel;
    return mode_e'(v);
  endfunction

  function automatic logic gate_retriggers(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction

  function automatic logic gate_paces(input mode_e m);
    return (m == M_TERM) || (m == M_SWSTB);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic idle_level(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge #(
  parameter logic GATE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic gate_prev,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATE_RST;
    else        gate_q <= gate_i;
  end

  assign gate_prev = gate_q;
  assign gate_rise = gate_i & ~gate_q;

endmodule

// File: rtl/ivt_down_core.sv
module ivt_down_core
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          gate_lvl,
  input  logic          gate_rise,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          mode_wr,
  input  logic [2:0]    mode_sel,
  output mode_e         mode_q,
  output stage_e        stage_q,
  output logic [CW:0]   rem_q,
  output logic [CW:0]   reload_q,
  output logic          moved_q,
  output mode_e         mode_n,
  output stage_e        stage_n,
  output logic [CW:0]   rem_n,
  output logic [CW:0]   reload_n,
  output logic          moved_n
);

  localparam int RW = CW + 1;
  localparam logic [RW-1:0] FULL = RW'(1) << CW;
  localparam logic [RW-1:0] ONE  = RW'(1);

  logic [RW-1:0] load_full;
  logic          restart;
  logic          tick;

  assign load_full = (load_val == '0) ? FULL : {1'b0, load_val};
  assign restart   = gate_rise && gate_retriggers(mode_q) && (stage_q != ST_IDLE);
  assign tick      = cnt_en && (stage_q != ST_IDLE) && (!gate_paces(mode_q) || gate_lvl);

  always_comb begin
    mode_n   = mode_q;
    stage_n  = stage_q;
    rem_n    = rem_q;
    reload_n = reload_q;
    moved_n  = moved_q;
    if (mode_wr) begin
      mode_n  = map_mode(mode_sel);
      stage_n = ST_IDLE;
      moved_n = 1'b0;
    end else if (load) begin
      reload_n = load_full;
      rem_n    = load_full;
      stage_n  = ST_RUN;
      moved_n  = 1'b0;
    end else if (restart) begin
      rem_n   = reload_q;
      stage_n = ST_RUN;
      moved_n = 1'b0;
    end else if (tick) begin
      moved_n = 1'b1;
      if (is_periodic(mode_q)) begin
        rem_n = (rem_q == ONE) ? reload_q : rem_q - ONE;
      end else begin
        rem_n = rem_q - ONE;
        case (stage_q)
          ST_RUN:   if (rem_q == ONE) stage_n = ST_AT_TC;
          ST_AT_TC: stage_n = ST_PAST;
          default:  stage_n = stage_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_TERM;
      stage_q  <= ST_IDLE;
      rem_q    <= '0;
      reload_q <= '0;
      moved_q  <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      stage_q  <= stage_n;
      rem_q    <= rem_n;
      reload_q <= reload_n;
      moved_q  <= moved_n;
    end
  end

endmodule

// File: rtl/ivt_wave_out.sv
module ivt_wave_out
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  mode_e       mode_n,
  input  stage_e      stage_n,
  input  logic [CW:0] rem_n,
  input  logic [CW:0] reload_n,
  input  logic        moved_n,
  output logic        out_q
);

  logic lvl_n;

  always_comb begin
    if (stage_n == ST_IDLE) begin
      lvl_n = idle_level(mode_n);
    end else begin
      case (mode_n)
        M_TERM:    lvl_n = (stage_n != ST_RUN);
        M_ONESHOT: lvl_n = (stage_n == ST_RUN);
        M_RATE:    lvl_n = moved_n && (rem_n == reload_n);
        M_SQUARE:  lvl_n = (rem_n > (reload_n >> 1));
        default:   lvl_n = (stage_n == ST_AT_TC);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= lvl_n;
  end

endmodule

// File: rtl/ivt_count_view.sv
module ivt_count_view
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  mode_e         mode_q,
  input  logic [CW:0]   rem_q,
  input  logic [CW:0]   reload_q,
  output logic [CW-1:0] count
);

  localparam int DW = CW + 2;

  logic [DW-1:0] twice;
  logic [DW-1:0] reload_x;
  logic [DW-1:0] sq_val;

  assign twice    = {rem_q, 1'b0};
  assign reload_x = {1'b0, reload_q};
  assign sq_val   = (twice > reload_x) ? twice - reload_x : twice;

  always_comb begin
    if (mode_q == M_SQUARE) count = sq_val[CW-1:0];
    else                    count = rem_q[CW-1:0];
  end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int   CW       = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          mode_wr_i,
  input  logic [2:0]    mode_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);

  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic gate_prev, gate_rise;

  ivt_gate_edge #(.GATE_RST(GATE_RST)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .gate_i(gate_i),
    .gate_prev(gate_prev), .gate_rise(gate_rise)
  );

  mode_e       mode_q, mode_n;
  stage_e      stage_q, stage_n;
  logic [CW:0] rem_q, rem_n, reload_q, reload_n;
  logic        moved_q, moved_n;

  ivt_down_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en),
    .gate_lvl(gate_i), .gate_rise(gate_rise),
    .load(load_i), .load_val(load_val_i),
    .mode_wr(mode_wr_i), .mode_sel(mode_i),
    .mode_q(mode_q), .stage_q(stage_q), .rem_q(rem_q),
    .reload_q(reload_q), .moved_q(moved_q),
    .mode_n(mode_n), .stage_n(stage_n), .rem_n(rem_n),
    .reload_n(reload_n), .moved_n(moved_n)
  );

  ivt_wave_out #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_sync_n),
    .mode_n(mode_n), .stage_n(stage_n), .rem_n(rem_n),
    .reload_n(reload_n), .moved_n(moved_n), .out_q(out_o)
  );

  ivt_count_view #(.CW(CW)) u_view (
    .mode_q(mode_q), .rem_q(rem_q), .reload_q(reload_q), .count(count_o)
  );

endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          gate_i,
  input logic          gate_prev,
  input logic          load_i,
  input logic [CW-1:0] load_val_i,
  input logic          mode_wr_i,
  input logic [2:0]    mode_i,
  input logic [2:0]    mode_q,
  input logic [1:0]    stage_q,
  input logic          out_o,
  input logic [CW-1:0] count_o
);

  logic rise;
  assign rise = gate_i && !gate_prev;

  // R10: cycles without enable, load, mode write or gate edge change nothing
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_i && !mode_wr_i && !rise) |=> ($stable(count_o) && $stable(out_o)));

  // R11: mode write lands on the idle level of the written mode
  p_idle_lvl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (out_o == ($past(mode_i) == 3'd1 || $past(mode_i) == 3'd2 ||
                             $past(mode_i) == 3'd3 || $past(mode_i) == 3'd6 ||
                             $past(mode_i) == 3'd7)));

  // R1: after a load the reader sees the loaded value
  p_load_show_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !mode_wr_i) |=> (count_o == $past(load_val_i)));

  // R4: terminal flag stays high
  p_term_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && stage_q != 2'd0 && out_o && !load_i && !mode_wr_i) |=> out_o);

  // R5: spent one-shot stays low without a trigger
  p_shot_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && stage_q != 2'd0 && !out_o && !load_i && !mode_wr_i && !rise)
    |=> !out_o);

endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .gate_i(gate_i),
  .gate_prev(gate_prev), .load_i(load_i), .load_val_i(load_val_i),
  .mode_wr_i(mode_wr_i), .mode_i(mode_i), .mode_q(mode_q),
  .stage_q(stage_q), .out_o(out_o), .count_o(count_o)
);

// File: tb/tb_ivt_channel.sv
`timescale 1ns/1ps
module tb_ivt_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en, gate_i, load_i, mode_wr_i;
  logic [15:0] load_val_i;
  logic [2:0]  mode_i;
  logic        out_o;
  logic [15:0] count_o;

  always #2 clk = ~clk;

  ivt_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate_i(gate_i),
    .load_i(load_i), .load_val_i(load_val_i), .mode_wr_i(mode_wr_i),
    .mode_i(mode_i), .out_o(out_o), .count_o(count_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m = 0, nval = 0, d = 0;
  bit idle = 1, gp = 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic string mtag(int mm);
    case (mm)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag);
    int eo, ec;
    if (idle) eo = (m == 1 || m == 2 || m == 3);
    else case (m)
      0: eo = (d >= nval);
      1: eo = (d < nval);
      2: eo = ((d % nval) == 0) && (d != 0);
      3: eo = (d % nval) < ((nval + 1) / 2);
      default: eo = (d == nval);
    endcase
    n_chk++;
    if (out_o !== eo[0]) begin
      n_fail++;
      $display("FAIL %s out_o=%0d expected=%0d (mode %0d N=%0d d=%0d)", tag, out_o, eo, m, nval, d);
    end
    if (!idle) begin
      if (m == 2)      ec = nval - (d % nval);
      else if (m == 3) ec = nval - ((2 * d) % nval);
      else             ec = nval - d;
      ec = ec & 16'hffff;
      n_chk++;
      if (count_o !== ec[15:0]) begin
        n_fail++;
        $display("FAIL %s count_o=%0d expected=%0d (mode %0d N=%0d d=%0d)", tag, count_o, ec, m, nval, d);
      end
    end
  endtask

  task automatic cyc(input bit en, input bit g, input bit ld, input int val,
                     input bit mw, input int mv, input string tag);
    bit rise;
    cnt_en = en; gate_i = g; load_i = ld; load_val_i = val[15:0];
    mode_wr_i = mw; mode_i = mv[2:0];
    @(posedge clk);
    rise = g && !gp;
    if (mw) begin
      m = (mv == 6) ? 2 : (mv == 7) ? 3 : mv;
      idle = 1; d = 0;
    end else if (ld) begin
      nval = (val[15:0] == 0) ? 65536 : int'(val[15:0]);
      d = 0; idle = 0;
    end else if (!idle && rise && (m == 1 || m == 2 || m == 3 || m == 5)) begin
      d = 0;
    end else if (!idle && en && (!(m == 0 || m == 4) || g)) begin
      d++;
    end
    gp = g;
    @(negedge clk);
    load_i = 0; mode_wr_i = 0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int nlist[7] = '{1, 2, 3, 4, 5, 8, 9};
    rst_n = 0; cnt_en = 0; gate_i = 1; load_i = 0; load_val_i = 0;
    mode_wr_i = 0; mode_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11: reset state idle mode 0, out low, count zero
    n_chk++;
    if (out_o !== 1'b0 || count_o !== 16'd0) begin
      n_fail++;
      $display("FAIL R11 reset out=%0d count=%0d expected out=0 count=0", out_o, count_o);
    end

    // sweep every selector and several reload values
    for (int sel = 0; sel < 8; sel++) begin
      for (int k = 0; k < 7; k++) begin
        string t;
        t = (sel >= 6) ? "R2" : mtag(sel);
        cyc(0, 1, 0, 0, 1, sel, "R11");
        cyc(0, 1, 1, nlist[k], 0, 0, "R1");
        for (int c = 0; c < 3 * nlist[k] + 6; c++)
          cyc((c % 3) != 2, 1, 0, 0, 0, 0, (c % 3 == 2) ? "R10" : t);
        cyc(0, 1, 0, 0, 0, 0, "R9");
      end
    end

    // R3: gate pauses modes 0 and 4
    for (int mm = 0; mm < 5; mm += 4) begin
      cyc(0, 1, 0, 0, 1, mm, "R11");
      cyc(0, 1, 1, 7, 0, 0, "R3");
      for (int c = 0; c < 20; c++) cyc(1, (c % 4) < 2, 0, 0, 0, 0, "R3");
    end
    // R3: gate rise restarts modes 1,2,3,5
    for (int mm = 1; mm < 6; mm++) begin
      if (mm == 4) continue;
      cyc(0, 1, 0, 0, 1, mm, "R11");
      cyc(0, 1, 1, 6, 0, 0, "R3");
      for (int c = 0; c < 4; c++) cyc(1, 1, 0, 0, 0, 0, "R3");
      cyc(1, 0, 0, 0, 0, 0, "R3");
      cyc(1, 0, 0, 0, 0, 0, "R3");
      cyc(1, 1, 0, 0, 0, 0, "R3");
      for (int c = 0; c < 10; c++) cyc(1, 1, 0, 0, 0, 0, "R3");
    end

    // R10: load with enable in the same edge, mid-run reload in mode 2
    cyc(0, 1, 0, 0, 1, 2, "R11");
    cyc(1, 1, 1, 5, 0, 0, "R10");
    for (int c = 0; c < 3; c++) cyc(1, 1, 0, 0, 0, 0, "R9");
    cyc(1, 1, 1, 3, 0, 0, "R10");
    for (int c = 0; c < 8; c++) cyc(1, 1, 0, 0, 0, 0, "R6");

    // R11: mode write while running parks the channel
    cyc(0, 1, 0, 0, 1, 1, "R11");
    cyc(0, 1, 1, 4, 0, 0, "R5");
    cyc(1, 1, 0, 0, 0, 0, "R5");
    cyc(1, 1, 0, 0, 1, 4, "R11");
    for (int c = 0; c < 3; c++) cyc(1, 1, 0, 0, 0, 0, "R11");

    // R1: zero load counts 65536 in mode 0 and wraps the readout
    cyc(0, 1, 0, 0, 1, 0, "R11");
    cyc(0, 1, 1, 0, 0, 0, "R1");
    for (int c = 0; c < 65539; c++) cyc(1, 1, 0, 0, 0, 0, "R1");

    // R9: zero load in mode 2
    cyc(0, 1, 0, 0, 1, 2, "R11");
    cyc(0, 1, 1, 0, 0, 0, "R9");
    for (int c = 0; c < 40; c++) cyc(1, 1, 0, 0, 0, 0, "R9");

    done = 1;
    report();
  end

endmodule